// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a behavioural model of one programmable logic cell. It takes four data inputs (`x_i`, `y_i`, `w_i`, `z_i`) and a feedback input, and a flat configuration vector sets its behaviour. The cell has two 3-input look-up tables. Both tables take the same three inputs: X, Y, and a third input chosen by a small selector. That selector can pass W, the AND of W and Z, or the feedback input. A second selector picks the input of the single flip-flop. That flip-flop has an asynchronous set/reset, and a configuration bit chooses whether it sets or resets.

The centre output is either the register value or the Z input, which skips the register. The feedback output makes the same choice under its own bit. Two enable bits place the centre value on the X and Y neighbour outputs. A neighbour output that is not enabled reads 0. Each truth table is held in configuration as the complement of the function it computes. A selector whose select bits are all low falls back to a fixed default source. The configuration is loaded elsewhere and is held steady while the cell runs.

Top module: `lcell_top`

## Requirements
- R1: The X table is `cfg_i[7:0]` and the Y table is `cfg_i[15:8]`. Each table is indexed by {third input, `y_i`, `x_i``}, so the third input is index bit 2 and `x_i` is bit 0. The look-up output (`xl_o`, `yl_o`) is the complement of the stored bit at that index.
- R2: When `cfg_i[16]` and `cfg_i[17]` are both 0, the third look-up input is `w_i`.
- R3: `cfg_i[16]`=1 makes the third input `w_i & z_i`. Otherwise `cfg_i[17]`=1 makes it `fb_i`. When both bits are 1, `w_i & z_i` wins.
- R4: The register input is `z_i` when `cfg_i[18]`=1. Otherwise it is the Y look-up output when `cfg_i[19]`=1. When both are 0, it is the X look-up output. `cfg_i[18]` wins over `cfg_i[19]`.
- R5: The register loads its selected input on each rising edge of `clk_i` while `sr_n_i` is high.
- R6: While `sr_n_i` is low, the register is held at 1 if `cfg_i[24]`=0 and at 0 if `cfg_i[24]`=1. This takes effect without waiting for a clock edge.
- R7: With `cfg_i[20]`=1 the centre value is `z_i`, with no clock delay; otherwise it is the register. With `cfg_i[21]`=1, `fb_o` is `z_i`; otherwise `fb_o` is the register.
- R8: `xo_o` is the centre value when `cfg_i[22]`=1 and 0 otherwise. `yo_o` works the same way under `cfg_i[23]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| sr_n_i | input | 1 | Asynchronous set/reset, active low |
| cfg_i | input | 25 | Configuration: two inverted truth tables and select bits |
| x_i | input | 1 | Cell input X |
| y_i | input | 1 | Cell input Y |
| w_i | input | 1 | Cell input W |
| z_i | input | 1 | Cell input Z |
| fb_i | input | 1 | Feedback line input |
| xo_o | output | 1 | X neighbour output |
| yo_o | output | 1 | Y neighbour output |
| fb_o | output | 1 | Feedback line output |
| xl_o | output | 1 | X look-up output |
| yl_o | output | 1 | Y look-up output |

## Verification
The look-up tables are tried with every one of the 256 table values at all eight indices. The Y table is loaded with the complement of the X table, so a swapped table or a missing inversion shows up at once. The third-input selector is tried with a table whose output equals index bit 2. W, Z and feedback values that disagree then reveal which source was picked and which bit has priority. The register path is driven through all four register-select combinations and sixteen input patterns, so Z, the Y look-up and the X look-up each give a different captured value. The bypass, enable and set/reset-polarity cases each hold the register at a value opposite to the one the bypass path or the disabled output should show.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LUT_K   = 3;
  localparam int TBL_W   = 1 << LUT_K;
  localparam int N_LUT   = 2;
  localparam int SEL_LSB = N_LUT * TBL_W;

  // select-bit positions inside the configuration vector
  localparam int B_WM_AND = SEL_LSB + 0;
  localparam int B_WM_FB  = SEL_LSB + 1;
  localparam int B_RG_Z   = SEL_LSB + 2;
  localparam int B_RG_YL  = SEL_LSB + 3;
  localparam int B_BYP_C  = SEL_LSB + 4;
  localparam int B_BYP_FB = SEL_LSB + 5;
  localparam int B_C_XO   = SEL_LSB + 6;
  localparam int B_C_YO   = SEL_LSB + 7;
  localparam int B_SR_SEL = SEL_LSB + 8;
  localparam int CFG_W    = SEL_LSB + 9;

  // a table stores the complement of the function it computes
  function automatic logic lut_eval(input logic [TBL_W-1:0] inv_tbl,
                                    input logic [LUT_K-1:0] idx);
    return ~inv_tbl[idx];
  endfunction

  // two-select priority pick: lower select wins, default when none set
  function automatic logic prio_pick(input logic s0, input logic s1,
                                     input logic a0, input logic a1,
                                     input logic dflt);
    if (s0)      return a0;
    else if (s1) return a1;
    else         return dflt;
  endfunction
endpackage

// File: rtl/lcell_lut.sv
module lcell_lut
  import lcell_pkg::*;
(
  input  logic [TBL_W-1:0] tbl_inv,
  input  logic [LUT_K-1:0] idx,
  output logic             out
);
  always_comb out = lut_eval(tbl_inv, idx);
endmodule

// File: rtl/lcell_srcmux.sv
module lcell_srcmux
  import lcell_pkg::*;
(
  input  logic sel0,
  input  logic sel1,
  input  logic src0,
  input  logic src1,
  input  logic dflt,
  output logic out
);
  always_comb out = prio_pick(sel0, sel1, src0, src1, dflt);
endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
  input  logic clk,
  input  logic sr_n,
  input  logic sr_sel,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge sr_n) begin
    if (!sr_n) q <= ~sr_sel;
    else       q <= d;
  end

  // R5
  reg_capture_chk: assert property (@(posedge clk) disable iff (!sr_n)
    sr_n |=> q == $past(d));
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic             clk_i,
  input  logic             sr_n_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             x_i,
  input  logic             y_i,
  input  logic             w_i,
  input  logic             z_i,
  input  logic             fb_i,
  output logic             xo_o,
  output logic             yo_o,
  output logic             fb_o,
  output logic             xl_o,
  output logic             yl_o
);
  logic             ia_w;      // internal AND of W and Z
  logic             wm_w;      // third look-up input
  logic [N_LUT-1:0] lut_w;     // [0]=X look-up, [1]=Y look-up
  logic             reg_d_w;
  logic             reg_q_w;
  logic             ctr_w;     // centre value

  always_comb ia_w = w_i & z_i;

  lcell_srcmux u_wmux (
    .sel0(cfg_i[B_WM_AND]), .sel1(cfg_i[B_WM_FB]),
    .src0(ia_w), .src1(fb_i), .dflt(w_i), .out(wm_w)
  );

  generate
    for (genvar g = 0; g < N_LUT; g++) begin : g_lut
      lcell_lut u_lut (
        .tbl_inv(cfg_i[g*TBL_W +: TBL_W]),
        .idx({wm_w, y_i, x_i}),
        .out(lut_w[g])
      );
    end
  endgenerate

  lcell_srcmux u_rmux (
    .sel0(cfg_i[B_RG_Z]), .sel1(cfg_i[B_RG_YL]),
    .src0(z_i), .src1(lut_w[1]), .dflt(lut_w[0]), .out(reg_d_w)
  );

  lcell_reg u_reg (
    .clk(clk_i), .sr_n(sr_n_i), .sr_sel(cfg_i[B_SR_SEL]),
    .d(reg_d_w), .q(reg_q_w)
  );

  always_comb begin
    ctr_w = cfg_i[B_BYP_C]  ? z_i : reg_q_w;
    fb_o  = cfg_i[B_BYP_FB] ? z_i : reg_q_w;
    xo_o  = cfg_i[B_C_XO] & ctr_w;
    yo_o  = cfg_i[B_C_YO] & ctr_w;
    xl_o  = lut_w[0];
    yl_o  = lut_w[1];
  end

  // R2
  wm_default_chk: assert property (@(posedge clk_i) disable iff (!sr_n_i)
    (!cfg_i[B_WM_AND] && !cfg_i[B_WM_FB]) |-> wm_w == w_i);
  // R3
  wm_and_prio_chk: assert property (@(posedge clk_i) disable iff (!sr_n_i)
    cfg_i[B_WM_AND] |-> wm_w == (w_i & z_i));
  // R4
  rd_default_chk: assert property (@(posedge clk_i) disable iff (!sr_n_i)
    (!cfg_i[B_RG_Z] && !cfg_i[B_RG_YL]) |-> reg_d_w == lut_w[0]);
  // R4
  rd_z_prio_chk: assert property (@(posedge clk_i) disable iff (!sr_n_i)
    cfg_i[B_RG_Z] |-> reg_d_w == z_i);
  // R7
  byp_centre_chk: assert property (@(posedge clk_i) disable iff (!sr_n_i)
    (cfg_i[B_BYP_C] && cfg_i[B_C_XO]) |-> xo_o == z_i);
  // R8
  xo_idle_chk: assert property (@(posedge clk_i) disable iff (!sr_n_i)
    !cfg_i[B_C_XO] |-> !xo_o);
  // R8
  yo_idle_chk: assert property (@(posedge clk_i) disable iff (!sr_n_i)
    !cfg_i[B_C_YO] |-> !yo_o);
endmodule

// File: tb/sim_lcell_top.sv
module sim_lcell_top;
  logic        clk = 1'b0;
  logic        sr_n = 1'b0;
  logic [24:0] cfg = '0;
  logic        x = 0, y = 0, w = 0, z = 0, fb = 0;
  logic        xo, yo, fbo, xl, yl;
  int          nchk = 0, nerr = 0;
  bit          done = 0;

  always #4 clk = ~clk;   // 125 MHz

  lcell_top u0 (
    .clk_i(clk), .sr_n_i(sr_n), .cfg_i(cfg),
    .x_i(x), .y_i(y), .w_i(w), .z_i(z), .fb_i(fb),
    .xo_o(xo), .yo_o(yo), .fb_o(fbo), .xl_o(xl), .yl_o(yl)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // reference: table bit selected by {m,b,a}, then complemented
  function automatic logic ref_lut(input logic [7:0] t, input logic a,
                                   input logic b, input logic m);
    int k;
    k = (m ? 4 : 0) + (b ? 2 : 0) + (a ? 1 : 0);
    return (t[k] == 1'b0);
  endfunction

  // R7 R6: polarity of the asynchronous action
  task automatic t_setreset();
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      cfg = '0; cfg[22] = 1'b1; cfg[23] = 1'b1; cfg[24] = p[0];
      sr_n = 1'b1;
      @(negedge clk); #1;
      sr_n = 1'b0; #1;
      chk("R6 xo", xo, p == 0);
      chk("R6 yo", yo, p == 0);
      @(negedge clk);
      sr_n = 1'b1;
    end
  endtask

  // R1: every table at every index
  task automatic t_lut_sweep();
    for (int t = 0; t < 256; t++) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        cfg = '0;
        cfg[7:0]  = t[7:0];
        cfg[15:8] = ~t[7:0];
        x = i[0]; y = i[1]; w = i[2]; z = 1'b0; fb = ~i[2];
        #1;
        chk("R1 xl", xl, ref_lut(t[7:0], i[0], i[1], i[2]));
        chk("R1 yl", yl, ref_lut(~t[7:0], i[0], i[1], i[2]));
      end
    end
  endtask

  // R2 R3: table 0x0F makes xl equal the third input
  task automatic t_wmux();
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 8; v++) begin
        logic e;
        @(negedge clk);
        cfg = '0; cfg[7:0] = 8'h0F; cfg[16] = s[0]; cfg[17] = s[1];
        x = 1'b0; y = 1'b1; w = v[0]; z = v[1]; fb = v[2];
        if (s[0])      e = v[0] & v[1];
        else if (s[1]) e = v[2];
        else           e = v[0];
        #1;
        chk(s == 0 ? "R2 wmux default" : "R3 wmux select", xl, e);
      end
    end
  endtask

  // R4 R5: register path, centre and feedback from the register
  task automatic t_regpath();
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 16; v++) begin
        logic e;
        @(negedge clk);
        cfg = '0; cfg[7:0] = 8'h3C; cfg[15:8] = 8'hA5;
        cfg[18] = s[0]; cfg[19] = s[1]; cfg[22] = 1'b1; cfg[23] = 1'b1;
        x = v[0]; y = v[1]; w = v[2]; z = v[3]; fb = 1'b0;
        if (s[0])      e = v[3];
        else if (s[1]) e = ref_lut(8'hA5, v[0], v[1], v[2]);
        else           e = ref_lut(8'h3C, v[0], v[1], v[2]);
        @(posedge clk); #1;
        chk(s == 0 ? "R4 reg default" : "R4 reg select", xo, e);
        chk("R5 yo", yo, e);
        chk("R7 fb from reg", fbo, e);
      end
    end
  endtask

  // R7: bypass with the register holding the opposite value
  task automatic t_bypass();
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      cfg = '0; cfg[18] = 1'b1; cfg[22] = 1'b1;
      z = ~v[0];
      @(posedge clk); #1;          // register now holds ~v
      @(negedge clk);
      cfg[18] = 1'b0; cfg[7:0] = {8{v[0]}};  // xl = ~v keeps reg at ~v
      cfg[20] = 1'b1; cfg[21] = 1'b1;
      z = v[0];
      #1;
      chk("R7 centre bypass", xo, v[0]);
      chk("R7 fb bypass", fbo, v[0]);
      @(posedge clk); #1;
      chk("R7 bypass keeps", xo, v[0]);
      @(negedge clk);
      cfg[20] = 1'b0; cfg[21] = 1'b0; #1;
      chk("R7 centre from reg", xo, ~v[0]);
      chk("R7 fb from reg", fbo, ~v[0]);
    end
  endtask

  // R8: disabled neighbour outputs read 0 while centre is 1
  task automatic t_outen();
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      cfg = '0; cfg[20] = 1'b1; cfg[22] = s[0]; cfg[23] = s[1];
      z = 1'b1; #1;
      chk("R8 xo", xo, s[0]);
      chk("R8 yo", yo, s[1]);
    end
  endtask

  initial begin
    #1;
    chk("R6 reset xo idle", xo, 1'b0);
    t_setreset();
    t_lut_sweep();
    t_wmux();
    t_regpath();
    t_bypass();
    t_outen();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule